// File: doc/BRIEF.md
# Boot Strap Snapshot Register

This block takes one picture of a general-purpose input bus early in boot and keeps it. When a single-cycle strap capture pulse arrives, the whole input word is latched as strap data and a valid flag is raised. From then until the next reset the stored word is frozen. Later capture pulses, activity on the input bus and any register writes leave it alone.

The captured word and the flag drive dedicated outputs. Both can also be read as read-only registers through a small register port. The same port holds the ordinary pin output value and output-enable registers, and it can read the live input bus. Writes to those neighbouring registers never reach the snapshot. The input bus is expected to be synchronized already. Pads and bus fabric sit outside this block.

Top module: `strap_snapshot`

## Requirements
- R1: While `rst` is high at a rising clock edge, `snap_word`, `snap_valid`, `pin_out` and `pin_oe` all become zero.
- R2: The first rising edge after reset at which `strap_pulse` is high stores the full `gpio_in` word into `snap_word`. The new value appears after that edge and not before it.
- R3: `snap_valid` goes from 0 to 1 at the edge that performs the first capture. It never rises without a capture pulse.
- R4: Once `snap_valid` is 1, further `strap_pulse` cycles change neither `snap_word` nor `snap_valid`; only reset re-arms the capture.
- R5: After the capture, any change on `gpio_in`, including returning to all zeros, leaves `snap_word` unchanged.
- R6: A read of register address 3 returns `snap_valid` in bit 0, with every upper bit zero.
- R7: A read of register address 4 returns the stored snapshot word.
- R8: Writes to register addresses 3 and 4 are ignored. The snapshot word and the flag keep their values.
- R9: A write to address 1 sets `pin_out`, and a write to address 2 sets `pin_oe`, from the following edge on. Neither write changes the snapshot word or the flag.
- R10: Address 0 reads the live `gpio_in` value. Addresses 5 to 7 read zero.
- R11: A capture pulse in a cycle where `rst` is high captures nothing. Reset wins, and the capture stays armed for the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gpio_in | input | 32 | Synchronized general-purpose input bus |
| strap_pulse | input | 1 | One-cycle capture request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| snap_word | output | 32 | Captured strap word |
| snap_valid | output | 1 | Set once a capture has happened |
| pin_out | output | 32 | Pin output value register |
| pin_oe | output | 32 | Pin output enable register |

## Verification
The hardest condition to reach is a capture pulse that arrives after the flag is already set, combined with an input word different from the one stored. Only that combination shows whether the capture is truly one-shot. For every table vector the bench therefore resets, captures one word and then drives its bitwise complement. It then fires a second pulse and expects the first word to remain. The reset-versus-pulse collision (R11) is produced by raising both inputs in the same cycle, and is followed by a real capture to prove the block is still armed.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LIVE = 3'd0,
        ADR_OUT  = 3'd1,
        ADR_OE   = 3'd2,
        ADR_FLAG = 3'd3,
        ADR_WORD = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic      en;
        reg_addr_e addr;
    } wr_req_t;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_DONE  = 1'b1
    } cap_state_e;

    function automatic logic addr_is_snap(input logic [ADDR_W-1:0] a);
        return (a == ADR_FLAG) || (a == ADR_WORD);
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             take,
    output logic [WIDTH-1:0] held_word,
    output logic             held_flag
);

    cap_state_e       state_q;
    logic [WIDTH-1:0] word_q;
    logic             fire;

    assign fire = take && (state_q == CAP_ARMED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_ARMED;
        end else if (fire) begin
            state_q <= CAP_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (fire) begin
            word_q <= bus_in;
        end
    end

    assign held_word = word_q;
    assign held_flag = (state_q == CAP_DONE);

endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
    import strap_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] oe_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
        end else if (req.en) begin
            if (req.addr == ADR_OUT) out_q <= wdata;
            if (req.addr == ADR_OE)  oe_q  <= wdata;
        end
    end

endmodule

// File: rtl/strap_read_mux.sv
module strap_read_mux
    import strap_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  live,
    input  logic [WIDTH-1:0]  out_q,
    input  logic [WIDTH-1:0]  oe_q,
    input  logic              flag,
    input  logic [WIDTH-1:0]  word,
    output logic [WIDTH-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_LIVE: rdata = live;
            ADR_OUT:  rdata = out_q;
            ADR_OE:   rdata = oe_q;
            ADR_FLAG: rdata = {{(WIDTH-1){1'b0}}, flag};
            ADR_WORD: rdata = word;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/strap_snapshot.sv
module strap_snapshot
    import strap_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  gpio_in,
    input  logic              strap_pulse,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    output logic [WIDTH-1:0]  snap_word,
    output logic              snap_valid,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);

    wr_req_t wr_req;

    assign wr_req.en   = reg_wr;
    assign wr_req.addr = reg_addr_e'(reg_addr);

    strap_capture #(.WIDTH(WIDTH)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .bus_in    (gpio_in),
        .take      (strap_pulse),
        .held_word (snap_word),
        .held_flag (snap_valid)
    );

    pin_ctrl_regs #(.WIDTH(WIDTH)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .req   (wr_req),
        .wdata (reg_wdata),
        .out_q (pin_out),
        .oe_q  (pin_oe)
    );

    strap_read_mux #(.WIDTH(WIDTH)) u_rd (
        .addr  (reg_addr),
        .live  (gpio_in),
        .out_q (pin_out),
        .oe_q  (pin_oe),
        .flag  (snap_valid),
        .word  (snap_word),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/strap_snapshot_chk.sv
module strap_snapshot_chk
    import strap_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [WIDTH-1:0]  gpio_in,
    input logic              strap_pulse,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WIDTH-1:0]  reg_rdata,
    input logic [WIDTH-1:0]  snap_word,
    input logic              snap_valid
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!snap_valid && snap_word == '0)); // R1

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (strap_pulse && !snap_valid) |=> (snap_valid && snap_word == $past(gpio_in))); // R2

    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!snap_valid && !strap_pulse) |=> !snap_valid); // R3

    AST_FLAG_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(snap_valid) |-> $past(strap_pulse)); // R3

    AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        snap_valid |=> (snap_valid && $stable(snap_word))); // R4

    AST_SNAP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && addr_is_snap(reg_addr) && !strap_pulse) |=> $stable(snap_word)); // R8

    AST_FLAG_READBACK: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_FLAG) |-> (reg_rdata == {{(WIDTH-1){1'b0}}, snap_valid})); // R6

    AST_WORD_READBACK: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_WORD) |-> (reg_rdata == snap_word)); // R7

endmodule

bind strap_snapshot strap_snapshot_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gpio_in     (gpio_in),
    .strap_pulse (strap_pulse),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .snap_word   (snap_word),
    .snap_valid  (snap_valid)
);

// File: tb/strap_snapshot_test.sv
module strap_snapshot_test;

    localparam int W = 32;
    localparam int NV = 8;
    localparam logic [W-1:0] VEC [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h8000_0001,
        32'h1234_5678, 32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h0000_8000
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  gpio_in = '0;
    logic          strap_pulse = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic [W-1:0]  snap_word;
    logic          snap_valid;
    logic [W-1:0]  pin_out;
    logic [W-1:0]  pin_oe;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    strap_snapshot uut (
        .clk(clk), .rst(rst), .gpio_in(gpio_in), .strap_pulse(strap_pulse),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .snap_word(snap_word), .snap_valid(snap_valid),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk) strap_pulse = 1'b1;
        @(negedge clk) strap_pulse = 1'b0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
        @(negedge clk) reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;
        do_reset();
        // R1 reset state
        check("R1 word", snap_word, '0);
        check("R1 valid", {31'b0, snap_valid}, 32'd0);
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);

        // table: capture, then complement plus second pulse must not update
        for (int i = 0; i < NV; i++) begin
            do_reset();
            gpio_in = VEC[i];
            @(negedge clk) strap_pulse = 1'b1;
            #1 check("R2 not before edge", snap_word, '0);
            @(negedge clk) strap_pulse = 1'b0;
            check("R2 capture", snap_word, VEC[i]);
            check("R3 valid set", {31'b0, snap_valid}, 32'd1);
            gpio_in = ~VEC[i];
            pulse();
            check("R4 second pulse word", snap_word, VEC[i]);
            check("R4 second pulse valid", {31'b0, snap_valid}, 32'd1);
            reg_read(3'd4, rd);
            check("R7 word reg", rd, VEC[i]);
        end

        // R3: no pulse, no flag; R6 flag reads zero before capture
        do_reset();
        gpio_in = 32'h5555_AAAA;
        repeat (3) @(negedge clk);
        check("R3 no pulse", {31'b0, snap_valid}, 32'd0);
        reg_read(3'd3, rd);
        check("R6 flag reg before", rd, 32'd0);
        // R10 live read and unmapped
        reg_read(3'd0, rd);
        check("R10 live read", rd, 32'h5555_AAAA);
        for (int a = 5; a < 8; a++) begin
            reg_read(a[2:0], rd);
            check("R10 unmapped zero", rd, 32'd0);
        end

        // R11 pulse during reset is ignored, capture stays armed
        @(negedge clk) begin rst = 1'b1; strap_pulse = 1'b1; end
        @(negedge clk) begin rst = 1'b0; strap_pulse = 1'b0; end
        check("R11 valid after collision", {31'b0, snap_valid}, 32'd0);
        check("R11 word after collision", snap_word, '0);
        gpio_in = 32'hC3C3_3C3C;
        pulse();
        check("R11 armed capture", snap_word, 32'hC3C3_3C3C);
        reg_read(3'd3, rd);
        check("R6 flag reg after", rd, 32'd1);

        // R5 input release after capture
        gpio_in = '0;
        repeat (4) @(negedge clk);
        check("R5 input released", snap_word, 32'hC3C3_3C3C);

        // R8 writes to snapshot registers ignored
        reg_write(3'd4, 32'h1111_2222);
        reg_write(3'd3, 32'd0);
        check("R8 word after write", snap_word, 32'hC3C3_3C3C);
        check("R8 valid after write", {31'b0, snap_valid}, 32'd1);

        // R9 pin registers update, snapshot untouched
        reg_write(3'd1, 32'hFACE_0001);
        check("R9 pin_out", pin_out, 32'hFACE_0001);
        reg_write(3'd2, 32'h0000_FFFF);
        check("R9 pin_oe", pin_oe, 32'h0000_FFFF);
        reg_read(3'd1, rd);
        check("R9 out readback", rd, 32'hFACE_0001);
        check("R9 word untouched", snap_word, 32'hC3C3_3C3C);
        check("R9 valid untouched", {31'b0, snap_valid}, 32'd1);

        // R9 before capture: pin writes must not set the flag
        do_reset();
        reg_write(3'd1, 32'hFFFF_FFFF);
        reg_write(3'd2, 32'hFFFF_FFFF);
        check("R9 no flag from pin write", {31'b0, snap_valid}, 32'd0);
        check("R1 word stays zero", snap_word, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule